// File: doc/BRIEF.md
# Twin-Predicated Compress/Expand Sequencer

This block produces the ordered list of register pairings for a one-source, one-destination vector operation in which the source and the destination each carry their own predicate mask. A command gives a length, two masks, a vector/scalar tag for each side and a base register for each side. The block then hands out (source register, destination register) pairs, one per accepted handshake. Source elements whose mask bit is clear are passed over, which packs the enabled sources together (compress). Destination elements whose mask bit is clear are also passed over, which spreads those packed values across the enabled destination slots (expand).

The two sides advance independently, each with its own element offset. A side tagged as scalar stays at offset 0 throughout. An all-ones source mask reduces the operation to a plain expand, and an all-ones destination mask reduces it to a plain compress. A caller that has no predicate for a side simply supplies all ones. Each search step is done by a combinational next-set-bit scan, so a pair is offered in the same cycle its offsets are found. The data movement for each pair is left to a downstream unit.

Top module: `tp_twin_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `pair_valid` and `done` are all low.
- R2: A command is taken only when `cmd_start` is high while the block is idle. The length, masks, tags and bases are captured at that edge. A `cmd_start`, or any change to the command inputs, while the block is busy has no effect on the pairs it produces.
- R3: For a vector source, the source offsets of the emitted pairs are the set bits of the source mask below the length, in ascending order. Bit k of a mask belongs to element k.
- R4: For a vector destination, the destination offsets of the emitted pairs are the set bits of the destination mask below the length, in ascending order.
- R5: The n-th pair joins the n-th enabled source element with the n-th enabled destination element. The sequence ends as soon as either side has no further enabled element below the length. When both sides are vector, the pair count is therefore the smaller of the two enabled-element counts.
- R6: A scalar-tagged side uses offset 0 in every pair. It takes part only if bit 0 of its mask is set; otherwise no pair is emitted. With one side scalar and the other vector, one pair is emitted for each enabled element of the vector side.
- R7: When both sides are scalar, at most one pair is emitted, with both offsets at 0. That pair is emitted only when the length is nonzero and bit 0 of both masks is set.
- R8: A length of zero produces no pair, and the command still completes with `done`.
- R9: `pair_src` equals the source base plus the source offset, and `pair_dst` equals the destination base plus the destination offset, both modulo 2^REG_W.
- R10: While `pair_valid` is high and `pair_ready` is low, `pair_valid`, `pair_src` and `pair_dst` hold their values. Each cycle with both signals high consumes exactly one pair.
- R11: Once the last pair has been consumed, or once no pair can be formed, `done` is high for exactly one cycle. `pair_valid` is low in that cycle, and `busy` is low in the cycle after it.
- R12: An all-ones source mask yields one pair per enabled destination element, and an all-ones destination mask yields one pair per enabled source element (both sides vector, length at full width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command strobe, accepted only when idle |
| cmd_vl | input | IDX_W | Number of elements, 0 to MAX_VL |
| cmd_src_mask | input | MAX_VL | Source predicate, bit k for element k |
| cmd_dst_mask | input | MAX_VL | Destination predicate, bit k for element k |
| cmd_src_vec | input | 1 | 1 = source is vector, 0 = scalar |
| cmd_dst_vec | input | 1 | 1 = destination is vector, 0 = scalar |
| cmd_src_base | input | REG_W | First source register |
| cmd_dst_base | input | REG_W | First destination register |
| pair_valid | output | 1 | A pair is offered |
| pair_ready | input | 1 | The consumer accepts the offered pair |
| pair_src | output | REG_W | Source register of the offered pair |
| pair_dst | output | REG_W | Destination register of the offered pair |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |

## Verification
The bench builds the block with MAX_VL = 4 and REG_W = 3. This small configuration makes it possible to run every pair of 4-bit masks at every length from 0 to 4 under all four scalar/vector tag combinations. That sweep covers empty masks, full masks, exhaustion on either side first, and the pure compress and pure expand cases. The 3-bit register field makes the base-plus-offset sums wrap often. A pseudo-random ready pattern stalls offered pairs, and stray start strobes together with changing command inputs during a run show that the captured command is left untouched.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {
    TP_IDLE = 2'd0,
    TP_RUN  = 2'd1,
    TP_FIN  = 2'd2
  } tp_state_e;
endpackage

// File: rtl/tp_next_set.sv
// Finds the lowest set mask bit at position >= from and < limit.
module tp_next_set #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] mask,
  input  logic [IDX_W-1:0]  from,
  input  logic [IDX_W-1:0]  limit,
  output logic              hit,
  output logic [IDX_W-1:0]  pos
);
  logic [MAX_VL-1:0] cand;

  for (genvar k = 0; k < MAX_VL; k++) begin : g_cand
    localparam logic [IDX_W-1:0] KPOS = IDX_W'(k);
    assign cand[k] = mask[k] && (KPOS >= from) && (KPOS < limit);
  end

  always_comb begin
    hit = |cand;
    pos = '0;
    for (int k = MAX_VL - 1; k >= 0; k--) begin
      if (cand[k]) pos = IDX_W'(k);
    end
  end
endmodule

// File: rtl/tp_side_scan.sv
// One side of the sequencer: vector sides search forward, scalar sides pin offset 0.
module tp_side_scan #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] mask,
  input  logic              is_vec,
  input  logic [IDX_W-1:0]  from,
  input  logic [IDX_W-1:0]  limit,
  output logic              hit,
  output logic [IDX_W-1:0]  pos
);
  logic             vec_hit;
  logic [IDX_W-1:0] vec_pos;
  logic             scl_hit;

  tp_next_set #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_find (
    .mask  (mask),
    .from  (from),
    .limit (limit),
    .hit   (vec_hit),
    .pos   (vec_pos)
  );

  assign scl_hit = mask[0] && (limit != '0);

  always_comb begin
    if (is_vec) begin
      hit = vec_hit;
      pos = vec_pos;
    end else begin
      hit = scl_hit;
      pos = '0;
    end
  end
endmodule

// File: rtl/tp_twin_seq.sv
module tp_twin_seq
  import tp_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int REG_W  = 7,
  localparam int IDX_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [IDX_W-1:0]  cmd_vl,
  input  logic [MAX_VL-1:0] cmd_src_mask,
  input  logic [MAX_VL-1:0] cmd_dst_mask,
  input  logic              cmd_src_vec,
  input  logic              cmd_dst_vec,
  input  logic [REG_W-1:0]  cmd_src_base,
  input  logic [REG_W-1:0]  cmd_dst_base,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [REG_W-1:0]  pair_src,
  output logic [REG_W-1:0]  pair_dst,
  output logic              busy,
  output logic              done
);
  localparam logic [MAX_VL-1:0] BIT0 = MAX_VL'(1);

  tp_state_e         state_q, state_n;
  logic [IDX_W-1:0]  vl_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic              svec_q, dvec_q;
  logic [REG_W-1:0]  sbase_q, dbase_q;
  logic [IDX_W-1:0]  i_q, i_n, j_q, j_n;
  logic              cfg_load, idx_en, accept;
  logic              s_hit, d_hit;
  logic [IDX_W-1:0]  s_pos, d_pos;

  tp_side_scan #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_src_scan (
    .mask (smask_q), .is_vec (svec_q), .from (i_q), .limit (vl_q),
    .hit  (s_hit),   .pos    (s_pos)
  );

  tp_side_scan #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_dst_scan (
    .mask (dmask_q), .is_vec (dvec_q), .from (j_q), .limit (vl_q),
    .hit  (d_hit),   .pos    (d_pos)
  );

  assign cfg_load   = (state_q == TP_IDLE) && cmd_start;
  assign pair_valid = (state_q == TP_RUN) && s_hit && d_hit;
  assign accept     = pair_valid && pair_ready;
  assign pair_src   = sbase_q + REG_W'(s_pos);
  assign pair_dst   = dbase_q + REG_W'(d_pos);
  assign busy       = (state_q != TP_IDLE);
  assign done       = (state_q == TP_FIN);
  assign idx_en     = cfg_load || accept;

  // next-state logic
  always_comb begin
    state_n = state_q;
    i_n     = i_q;
    j_n     = j_q;
    unique case (state_q)
      TP_IDLE: begin
        if (cmd_start) begin
          state_n = TP_RUN;
          i_n     = '0;
          j_n     = '0;
        end
      end
      TP_RUN: begin
        if (!(s_hit && d_hit)) begin
          state_n = TP_FIN;
        end else if (pair_ready) begin
          if (svec_q) i_n = s_pos + IDX_W'(1);
          if (dvec_q) j_n = d_pos + IDX_W'(1);
          if (!svec_q && !dvec_q) state_n = TP_FIN;
        end
      end
      TP_FIN:  state_n = TP_IDLE;
      default: state_n = TP_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TP_IDLE;
    else        state_q <= state_n;
  end

  // element offsets, written on command load or pair acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      j_q <= '0;
    end else if (idx_en) begin
      i_q <= i_n;
      j_q <= j_n;
    end
  end

  // command capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      smask_q <= '0;
      dmask_q <= '0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
    end else if (cfg_load) begin
      vl_q    <= cmd_vl;
      smask_q <= cmd_src_mask;
      dmask_q <= cmd_dst_mask;
      svec_q  <= cmd_src_vec;
      dvec_q  <= cmd_dst_vec;
      sbase_q <= cmd_src_base;
      dbase_q <= cmd_dst_base;
    end
  end

  // R10
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready |=> pair_valid && $stable(pair_src) && $stable(pair_dst));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pair_valid);

  // R3
  src_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> |(smask_q & (BIT0 << s_pos)) && (s_pos < vl_q));

  // R4
  dst_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> |(dmask_q & (BIT0 << d_pos)) && (d_pos < vl_q));

  // R7
  scalar_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !svec_q && !dvec_q |=> done);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (vl_q == '0) |-> !pair_valid);
endmodule

// File: tb/tb_tp_twin_seq.sv
module tb_tp_twin_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL     = 4;
  localparam int REG_W      = 3;
  localparam int IDX_W      = $clog2(MAX_VL + 1);

  logic              clk;
  logic              rst_n;
  logic              cmd_start;
  logic [IDX_W-1:0]  cmd_vl;
  logic [MAX_VL-1:0] cmd_src_mask, cmd_dst_mask;
  logic              cmd_src_vec, cmd_dst_vec;
  logic [REG_W-1:0]  cmd_src_base, cmd_dst_base;
  logic              pair_valid, pair_ready;
  logic [REG_W-1:0]  pair_src, pair_dst;
  logic              busy, done;

  int checks;
  int fails;
  logic [15:0] rng;
  int exp_s [MAX_VL];
  int exp_d [MAX_VL];
  int exp_cnt;

  tp_twin_seq #(.MAX_VL(MAX_VL), .REG_W(REG_W)) dut (
    .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_vl (cmd_vl),
    .cmd_src_mask (cmd_src_mask), .cmd_dst_mask (cmd_dst_mask),
    .cmd_src_vec (cmd_src_vec), .cmd_dst_vec (cmd_dst_vec),
    .cmd_src_base (cmd_src_base), .cmd_dst_base (cmd_dst_base),
    .pair_valid (pair_valid), .pair_ready (pair_ready),
    .pair_src (pair_src), .pair_dst (pair_dst), .busy (busy), .done (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step_rng();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
  endtask

  // Expected offsets straight from the pairing rules (R3..R8).
  task automatic build_exp(input int vl, input logic [MAX_VL-1:0] sm,
                           input logic [MAX_VL-1:0] dm, input bit sv, input bit dv);
    int i, j, si, di;
    bit sok, dok;
    i = 0; j = 0; exp_cnt = 0;
    forever begin
      if (sv) begin
        si = i;
        while ((si < vl) && !sm[si]) si++;
        sok = (si < vl);
      end else begin
        si = 0;
        sok = (vl > 0) && sm[0];
      end
      if (dv) begin
        di = j;
        while ((di < vl) && !dm[di]) di++;
        dok = (di < vl);
      end else begin
        di = 0;
        dok = (vl > 0) && dm[0];
      end
      if (!(sok && dok) || exp_cnt >= MAX_VL) break;
      exp_s[exp_cnt] = si;
      exp_d[exp_cnt] = di;
      exp_cnt++;
      if (!sv && !dv) break;
      if (sv) i = si + 1;
      if (dv) j = di + 1;
    end
  endtask

  task automatic run_cmd(input int vl, input logic [MAX_VL-1:0] sm,
                         input logic [MAX_VL-1:0] dm, input bit sv, input bit dv,
                         input int sb, input int db, input bit disturb);
    int k, cyc;
    bit seen_done, stalled;
    logic [REG_W-1:0] hold_s, hold_d;
    string cnt_tag;
    build_exp(vl, sm, dm, sv, dv);
    @(negedge clk);
    cmd_start    = 1'b1;
    cmd_vl       = IDX_W'(vl);
    cmd_src_mask = sm;
    cmd_dst_mask = dm;
    cmd_src_vec  = sv;
    cmd_dst_vec  = dv;
    cmd_src_base = REG_W'(sb);
    cmd_dst_base = REG_W'(db);
    k = 0; cyc = 0; seen_done = 0; stalled = 0;
    hold_s = '0; hold_d = '0;
    @(negedge clk);
    while (!seen_done && cyc < 100) begin
      step_rng();
      // R2: scramble command inputs while busy; one stray start in RUN
      cmd_start    = disturb && (cyc == 0);
      cmd_vl       = IDX_W'(rng[2:0] % (MAX_VL + 1));
      cmd_src_mask = rng[7:4];
      cmd_dst_mask = rng[11:8];
      cmd_src_vec  = rng[12];
      cmd_dst_vec  = rng[13];
      cmd_src_base = rng[2:0];
      cmd_dst_base = rng[5:3];
      pair_ready   = rng[0] | rng[3];
      if (stalled)
        chk(pair_valid && pair_src == hold_s && pair_dst == hold_d,
            "R10 held pair", int'(pair_src), int'(hold_s));
      stalled = 0;
      if (done) begin
        seen_done = 1;
        chk(!pair_valid, "R11 valid low during done", int'(pair_valid), 0);
      end else if (pair_valid) begin
        if (pair_ready) begin
          if (k < exp_cnt) begin
            chk(pair_src == REG_W'(sb + exp_s[k]), sv ? "R3 R9 src reg" : "R6 R9 src reg",
                int'(pair_src), (sb + exp_s[k]) % (1 << REG_W));
            chk(pair_dst == REG_W'(db + exp_d[k]), dv ? "R4 R9 dst reg" : "R6 R9 dst reg",
                int'(pair_dst), (db + exp_d[k]) % (1 << REG_W));
          end
          k++;
        end else begin
          stalled = 1;
          hold_s  = pair_src;
          hold_d  = pair_dst;
        end
      end
      @(negedge clk);
      cyc++;
    end
    cmd_start  = 1'b0;
    pair_ready = 1'b0;
    chk(seen_done, "R11 done reached", int'(seen_done), 1);
    chk(!busy && !done, "R11 idle after done", int'(busy) + 2 * int'(done), 0);
    if (vl == 0)                       cnt_tag = "R8 pair count";
    else if (!sv && !dv)               cnt_tag = "R7 pair count";
    else if (!sv || !dv)               cnt_tag = "R6 pair count";
    else if (vl == MAX_VL && (&sm || &dm)) cnt_tag = "R12 pair count";
    else                               cnt_tag = "R5 pair count";
    chk(k == exp_cnt, cnt_tag, k, exp_cnt);
    if (disturb) chk(k == exp_cnt, "R2 stray start ignored", k, exp_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; rng = 16'hACE1;
    rst_n = 1'b0; cmd_start = 1'b0; cmd_vl = '0;
    cmd_src_mask = '0; cmd_dst_mask = '0; cmd_src_vec = 1'b0; cmd_dst_vec = 1'b0;
    cmd_src_base = '0; cmd_dst_base = '0; pair_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !pair_valid && !done, "R1 reset idle",
        int'(busy) + 2 * int'(pair_valid) + 4 * int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pair_valid && !done, "R1 idle after release",
        int'(busy) + 2 * int'(pair_valid) + 4 * int'(done), 0);
    for (int vl = 0; vl <= MAX_VL; vl++)
      for (int sm = 0; sm < (1 << MAX_VL); sm++)
        for (int dm = 0; dm < (1 << MAX_VL); dm++)
          for (int tg = 0; tg < 4; tg++) begin
            step_rng();
            run_cmd(vl, MAX_VL'(sm), MAX_VL'(dm), tg[0], tg[1],
                    (sm + vl) % (1 << REG_W), (dm * 3 + tg) % (1 << REG_W), rng[5]);
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule